// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Port

This block is an 8-bit parallel port. Each pin can be an input or an output, and each input can raise an interrupt request on a rising or a falling transition that software selects. Pin levels pass through a two-stage synchronizer before any edge is detected. Each request is a single-clock strobe. The strobes leave the block twice: as a vector indexed by pin, and spread onto a sixteen-slot channel vector in the slots that a downstream priority encoder expects.

A small register interface gives access to four registers: the line level or output value, the direction, the edge polarity, and a control word. Setting the control bit turns on handshake mode. In this mode the two lowest pins become outputs and carry flags supplied from outside: pin 0 carries receive-buffer-full and pin 1 carries transmit-buffer-empty. A write that flips a pin's polarity bit cannot produce a false request on that pin.

Top module: `gpio_edge_port`

## Requirements
- R1: While reset is high and in the cycle after it, every register reads 0, `pin_oe`, `pin_out`, `pin_irq` and `chan_irq` are all 0, and `reg_rdata` is 0.
- R2: Register addresses are: 0 = level/output data, 1 = direction, 2 = edge polarity, 3 = control (bit 0 = handshake enable, other bits read 0). A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` shows the addressed register one clock after `reg_addr` is sampled. A read of address 0 returns the synchronized level of every pin, output pins included.
- R3: A direction bit of 1 makes the pin an output. An edge bit of 1 selects low-to-high transitions for that pin's request, and 0 selects high-to-low transitions.
- R4: A pin whose effective direction is output never raises a request.
- R5: A transition on `pin_in` sampled at clock edge k raises the pin's request after edge k+2. The request stays high for exactly one cycle.
- R6: Suppose a write to address 2 changes a pin's polarity bit. In that cycle, the pin raises no request, even if a transition is detected at the same edge.
- R7: When handshake is enabled, pins 0 and 1 are forced to outputs. `pin_out[0]` follows `rx_full` and `pin_out[1]` follows `tx_empty`, each one clock late. Data register bits 0 and 1 then do not reach the pins.
- R8: `pin_oe` and `pin_out` are registered. They follow the effective direction and the output data one clock after those values change.
- R9: Requests map to channels as follows: pins 0-3 to channels 0-3, pins 4-5 to channels 6-7, pins 6-7 to channels 14-15. The other channel bits are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Levels driven onto the pins |
| pin_oe | output | 8 | Per-pin output enable |
| rx_full | input | 1 | Receive-buffer-full flag for pin 0 |
| tx_empty | input | 1 | Transmit-buffer-empty flag for pin 1 |
| pin_irq | output | 8 | One-cycle request per pin |
| chan_irq | output | 16 | Requests placed in channel slots |

## Verification
The hardest case to reach is a polarity write that lands on the exact edge where the synchronizer presents the newly selected transition. Only then does the suppression rule decide the outcome. A directed sequence raises a pin, waits the two synchronizer cycles, and writes the flipped polarity bit on the third edge. The random phase also writes the edge register often while the pins toggle, so such collisions recur. A cycle-accurate bench model scores every output on every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_ADDR_W = 2;
  localparam int NUM_CHAN   = 16;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_LEVEL = 2'd0,
    REG_DIR   = 2'd1,
    REG_EDGE  = 2'd2,
    REG_CTRL  = 2'd3
  } reg_sel_e;

  // slot of the downstream priority encoder that each pin feeds
  function automatic int chan_of(input int pin);
    if (pin < 4)      return pin;
    else if (pin < 6) return pin + 2;
    else              return pin + 8;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [W-1:0]          wdata,
  input  logic [W-1:0]          level,
  output logic [W-1:0]          rdata,
  output logic [W-1:0]          data_q,
  output logic [W-1:0]          dir_q,
  output logic [W-1:0]          edge_q,
  output logic                  hs_q,
  output logic [W-1:0]          edge_keep
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      edge_q <= '0;
      hs_q   <= 1'b0;
    end else if (wr) begin
      unique case (sel)
        REG_LEVEL: data_q <= wdata;
        REG_DIR:   dir_q  <= wdata;
        REG_EDGE:  edge_q <= wdata;
        REG_CTRL:  hs_q   <= wdata[0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (sel)
        REG_LEVEL: rdata <= level;
        REG_DIR:   rdata <= dir_q;
        REG_EDGE:  rdata <= edge_q;
        REG_CTRL:  rdata <= {{(W-1){1'b0}}, hs_q};
      endcase
    end
  end

  // pins whose polarity flips in this cycle are silenced
  always_comb begin
    edge_keep = '1;
    if (wr && sel == REG_EDGE) edge_keep = ~(wdata ^ edge_q);
  end
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_sel,
  input  logic [W-1:0] in_mask,
  input  logic [W-1:0] keep,
  output logic [W-1:0] irq_q
);
  logic [W-1:0] prev;
  logic [W-1:0] hit;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      hit[i] = rise_sel[i] ? (level[i] & ~prev[i]) : (~level[i] & prev[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= '0;
      irq_q <= '0;
    end else begin
      prev  <= level;
      irq_q <= hit & in_mask & keep;
    end
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_chk
      a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_q[g] |=> !irq_q[g]);
      a_r3_polarity: assert property (@(posedge clk) disable iff (rst)
        irq_q[g] |-> ($past(level[g]) == $past(rise_sel[g]) &&
                      $past(prev[g]) != $past(level[g])));
    end
  endgenerate
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]          reg_wdata,
  output logic [W-1:0]          reg_rdata,
  input  logic [W-1:0]          pin_in,
  output logic [W-1:0]          pin_out,
  output logic [W-1:0]          pin_oe,
  input  logic                  rx_full,
  input  logic                  tx_empty,
  output logic [W-1:0]          pin_irq,
  output logic [NUM_CHAN-1:0]   chan_irq
);
  localparam logic [W-1:0] HS_PINS = {{(W-2){1'b0}}, 2'b11};

  logic [W-1:0] level, data_q, dir_q, edge_q, edge_keep, dir_eff, out_eff;
  logic         hs_q;

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(level)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .level(level), .rdata(reg_rdata), .data_q(data_q), .dir_q(dir_q),
    .edge_q(edge_q), .hs_q(hs_q), .edge_keep(edge_keep)
  );

  assign dir_eff = hs_q ? (dir_q | HS_PINS) : dir_q;
  assign out_eff = hs_q ? {data_q[W-1:2], tx_empty, rx_full} : data_q;

  gpio_edge #(.W(W)) u_edge (
    .clk(clk), .rst(rst), .level(level), .rise_sel(edge_q),
    .in_mask(~dir_eff), .keep(edge_keep), .irq_q(pin_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= '0;
      pin_out <= '0;
    end else begin
      pin_oe  <= dir_eff;
      pin_out <= out_eff;
    end
  end

  always_comb begin
    chan_irq = '0;
    for (int i = 0; i < W; i++) chan_irq[chan_of(i)] = pin_irq[i];
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pin_irq == '0 && pin_oe == '0 && pin_out == '0));
  a_r4_output_quiet: assert property (@(posedge clk) disable iff (rst)
    (pin_irq & $past(dir_eff)) == '0);
  a_r7_hs_forced_out: assert property (@(posedge clk) disable iff (rst)
    hs_q |=> pin_oe[1:0] == 2'b11);
  a_r7_hs_rx_flag: assert property (@(posedge clk) disable iff (rst)
    hs_q |=> pin_out[0] == $past(rx_full));
endmodule

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] pin_in = '0;
  logic rx_full = 1'b0, tx_empty = 1'b0;
  logic [W-1:0] reg_rdata, pin_out, pin_oe, pin_irq;
  logic [15:0] chan_irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_edge_port #(.W(W)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .rx_full(rx_full),
    .tx_empty(tx_empty), .pin_irq(pin_irq), .chan_irq(chan_irq)
  );

  // reference model built from the requirements
  logic [W-1:0] m_s1, m_s2, m_prev, m_data, m_dir, m_edge, m_irq, m_oe, m_out, m_rd;
  logic m_hs;

  function automatic logic [15:0] map_chan(input logic [W-1:0] v);
    logic [15:0] c = '0;
    for (int i = 0; i < 4; i++) c[i] = v[i];
    c[6] = v[4]; c[7] = v[5]; c[14] = v[6]; c[15] = v[7];
    return c;
  endfunction

  always @(posedge clk) begin
    logic [W-1:0] de, hit, keep;
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_data <= '0; m_dir <= '0;
      m_edge <= '0; m_irq <= '0; m_oe <= '0; m_out <= '0; m_rd <= '0; m_hs <= 0;
    end else begin
      de   = m_dir | (m_hs ? 8'h03 : 8'h00);
      hit  = (m_edge & m_s2 & ~m_prev) | (~m_edge & ~m_s2 & m_prev);
      keep = (reg_wr && reg_addr == 2'd2) ? ~(reg_wdata ^ m_edge) : 8'hFF;
      m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
      m_irq <= hit & ~de & keep;
      m_oe  <= de;
      m_out <= m_hs ? {m_data[7:2], tx_empty, rx_full} : m_data;
      case (reg_addr)
        2'd0: m_rd <= m_s2;
        2'd1: m_rd <= m_dir;
        2'd2: m_rd <= m_edge;
        default: m_rd <= {7'b0, m_hs};
      endcase
      if (reg_wr) case (reg_addr)
        2'd0: m_data <= reg_wdata;
        2'd1: m_dir  <= reg_wdata;
        2'd2: m_edge <= reg_wdata;
        default: m_hs <= reg_wdata[0];
      endcase
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R5 R3 R4 R6 pin_irq", pin_irq, m_irq);
    chk("R9 chan_irq", chan_irq, map_chan(m_irq));
    chk("R8 R7 pin_oe", pin_oe, m_oe);
    chk("R8 R7 pin_out", pin_out, m_out);
    chk("R2 reg_rdata", reg_rdata, m_rd);
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rst) compare_all();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  initial begin
    int hits;
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state seen in the cycle after reset
    @(negedge clk);
    chk("R1 pin_irq", pin_irq, 0); chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0); chk("R1 reg_rdata", reg_rdata, 0);
    chk("R1 chan_irq", chan_irq, 0);

    // R5: rising edge on pin 5, request after the third edge
    wr(2'd2, 8'hFF);
    repeat (3) tick();
    pin_in = 8'h20;
    tick(); tick();
    chk("R5 not early", pin_irq, 0);
    tick();
    chk("R5 pulse", pin_irq, 8'h20);
    chk("R9 pin5 to chan7", chan_irq, 16'h0080);
    tick();
    chk("R5 one cycle", pin_irq, 0);

    // R6: polarity flip on the very edge the rise is detected
    pin_in = 8'h21;
    tick(); tick();
    hits = 0;
    reg_wr = 1; reg_addr = 2'd2; reg_wdata = 8'hFE;
    tick(); reg_wr = 0;
    for (int k = 0; k < 4; k++) begin
      if (pin_irq[0]) hits++;
      tick();
    end
    chk("R6 suppressed", hits, 0);

    // R4: output pins are silent while toggling
    wr(2'd1, 8'hFF);
    hits = 0;
    for (int k = 0; k < 12; k++) begin
      pin_in = ~pin_in;
      tick();
      if (pin_irq != 0) hits++;
    end
    chk("R4 no requests", hits, 0);

    // R7: handshake flags onto pins 0 and 1
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hA0);
    wr(2'd3, 8'h01);
    rx_full = 1; tx_empty = 0;
    tick(); tick();
    chk("R7 flags", pin_out[1:0], 2'b01);
    chk("R7 forced oe", pin_oe, 8'h03);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ 8'($urandom());
      rx_full = 1'($urandom()); tx_empty = 1'($urandom());
      reg_addr = 2'($urandom());
      reg_wr = ($urandom_range(0, 5) == 0);
      reg_wdata = 8'($urandom());
      tick();
    end
    reg_wr = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule